// File: doc/BRIEF.md
# Interlocked Half-Bridge Gate Control

This block sits between the command logic and the two switch drivers of a half-bridge. It takes a high-side command, a low-side command, an active-low shutdown and one supply-good flag per side. All of these are already synchronised to `clk`. It produces one enable per switch.

The block has three protection layers:
- A cross-interlock refuses any request while both commands are high.
- The shutdown input forces both enables off.
- Each side's supply-good flag gates its own side.

The high-side path models the latency of an isolation link as a delay line, followed by a pulse-width enforcer. The enforcer stretches any on or off interval shorter than a minimum width to exactly that width. The low-side path does not stretch pulses. It uses a delay line of the same length, so both channels respond after the same number of cycles.

Shutdown and supply loss act on the next clock edge. They flush the affected delay line and abandon any stretch in progress.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While reset is asserted, and on the first edge after it, both enables are 0 and both delay lines hold only off values.
- R2: A side is requested only when its own command is 1 and the other command is 0. While both commands are 1, neither side is requested. When one command drops, the side whose command stays 1 becomes requested.
- R3: If `shdn_n` is 0 at a clock edge, both enables are 0 after that edge. Both delay lines and any pending stretch are cleared, so a command present during shutdown appears at the enable only LINK_DLY+1 edges after release.
- R4: If a side's supply-good flag is 0 at a clock edge, that side's enable is 0 after that edge and its delay line is cleared. The other side is unaffected.
- R5: Without stretching or blocking, a change in a side's request at an edge appears on that side's enable exactly LINK_DLY+1 edges later, on both channels.
- R6: A high-side on interval shorter than MIN_W cycles is extended to exactly MIN_W cycles.
- R7: A high-side off interval shorter than MIN_W cycles, between two on intervals, is extended to exactly MIN_W cycles.
- R8: The low-side path does not stretch: a one-cycle low-side request yields a one-cycle `en_lo` pulse.
- R9: `en_hi` and `en_lo` are never 1 in the same cycle. `en_lo` is held off while the high side is held on by stretching.
- R10: High-side intervals of MIN_W cycles or longer pass through with their length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi | input | 1 | High-side on command |
| cmd_lo | input | 1 | Low-side on command |
| shdn_n | input | 1 | Active-low shutdown of both sides |
| pgood_hi | input | 1 | High-side supply good |
| pgood_lo | input | 1 | Low-side supply good |
| en_hi | output | 1 | High-side switch enable |
| en_lo | output | 1 | Low-side switch enable |

## Verification
The bench targets these corner cases:
- **Single-cycle high-side pulse followed at once by a low-side request.** A design without the cross-hold would drive both switches on together.
- **Both commands high.** A design that gave either side priority would turn that side on instead of blocking both.
- **One-cycle gap in a long high-side pulse.** A missing off-stretch would pass a glitch to the gate.
- **Shutdown or supply loss during a stretch or with data in flight.** A design that failed to flush would let a stale command reach the enable after release.

The bench also compares a one-cycle low-side pulse against an equal high-side pulse. This catches a low path that wrongly stretches, or a latency mismatch between the channels.

// File: rtl/hb_gate_ctrl.sv
`timescale 1ns/1ps
module hb_gate_ctrl #(
  parameter int MIN_W    = 5,
  parameter int LINK_DLY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_hi,
  input  logic cmd_lo,
  input  logic shdn_n,
  input  logic pgood_hi,
  input  logic pgood_lo,
  output logic en_hi,
  output logic en_lo
);
  localparam int CW = $clog2(MIN_W + 1);
  localparam logic [CW-1:0] HOLD_LD = CW'(MIN_W - 1);
  localparam logic [CW-1:0] AGE_MAX = CW'(MIN_W);

  typedef enum logic [1:0] {S_IDLE, S_HON, S_TRK, S_HOFF} st_t;

  wire req_hi  = cmd_hi & ~cmd_lo;
  wire req_lo  = cmd_lo & ~cmd_hi;
  wire gate_hi = shdn_n & pgood_hi;
  wire gate_lo = shdn_n & pgood_lo;

  logic [LINK_DLY-1:0] dl_hi, dl_lo;
  wire tail_hi = dl_hi[LINK_DLY-1];
  wire tail_lo = dl_lo[LINK_DLY-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_hi <= '0;
      dl_lo <= '0;
    end else begin
      dl_hi <= gate_hi ? ((dl_hi << 1) | LINK_DLY'(req_hi)) : '0;
      dl_lo <= gate_lo ? ((dl_lo << 1) | LINK_DLY'(req_lo)) : '0;
    end
  end

  st_t st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic hi_nxt;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      S_IDLE: if (tail_hi) begin st_n = S_HON; cnt_n = HOLD_LD; end
      S_HON:
        if (cnt != '0) cnt_n = cnt - 1'b1;
        else if (tail_hi) st_n = S_TRK;
        else begin st_n = S_HOFF; cnt_n = HOLD_LD; end
      S_TRK: if (!tail_hi) begin st_n = S_HOFF; cnt_n = HOLD_LD; end
      S_HOFF:
        if (cnt != '0) cnt_n = cnt - 1'b1;
        else if (tail_hi) begin st_n = S_HON; cnt_n = HOLD_LD; end
        else st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
    if (!gate_hi) begin
      st_n  = S_IDLE;
      cnt_n = '0;
    end
    hi_nxt = (st_n == S_HON) || (st_n == S_TRK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      en_hi <= 1'b0;
      en_lo <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      en_hi <= hi_nxt;
      en_lo <= gate_lo & tail_lo & ~hi_nxt;
    end
  end

  logic [CW-1:0] hi_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_age <= AGE_MAX;
    else if (!gate_hi) hi_age <= AGE_MAX;
    else if (hi_nxt != en_hi) hi_age <= CW'(1);
    else if (hi_age < AGE_MAX) hi_age <= hi_age + 1'b1;
  end

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_hi && en_lo));
  a_r3_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (!en_hi && !en_lo));
  a_r4_pgood_hi: assert property (@(posedge clk) disable iff (!rst_n)
    !pgood_hi |=> !en_hi);
  a_r4_pgood_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !pgood_lo |=> !en_lo);
  // covers R7 as well: any ungated change of en_hi waits MIN_W cycles
  a_r6_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi && (hi_nxt != en_hi)) |-> (hi_age >= AGE_MAX));
  a_r2_both_block: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hi && cmd_lo) |=> !dl_hi[0] && !dl_lo[0]);
endmodule

// File: tb/test_hb_gate_ctrl.sv
`timescale 1ns/1ps
module test_hb_gate_ctrl;
  localparam int MW = 5;
  localparam int LD = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_hi = 0, cmd_lo = 0, shdn_n = 1, pgood_hi = 1, pgood_lo = 1;
  logic en_hi, en_lo;

  hb_gate_ctrl #(.MIN_W(MW), .LINK_DLY(LD)) i_hb_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .shdn_n(shdn_n), .pgood_hi(pgood_hi), .pgood_lo(pgood_lo),
    .en_hi(en_hi), .en_lo(en_lo));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  string tag = "R1";

  bit qh[LD], ql[LD];
  bit mh = 0, ml = 0;
  int age = MW;

  always @(posedge clk) begin
    bit rh, rl, gh, gl, xh, xl, nh;
    if (!rst_n) begin
      for (int i = 0; i < LD; i++) begin qh[i] = 0; ql[i] = 0; end
      mh = 0; ml = 0; age = MW;
    end else begin
      rh = cmd_hi && !cmd_lo;
      rl = cmd_lo && !cmd_hi;
      gh = shdn_n && pgood_hi;
      gl = shdn_n && pgood_lo;
      xh = qh[LD-1];
      xl = ql[LD-1];
      for (int i = LD-1; i > 0; i--) begin qh[i] = qh[i-1]; ql[i] = ql[i-1]; end
      qh[0] = rh;
      ql[0] = rl;
      if (!gh) begin
        for (int i = 0; i < LD; i++) qh[i] = 0;
        nh = 0; age = MW;
      end else begin
        nh = (age < MW) ? mh : xh;
        if (nh != mh) age = 1;
        else if (age < MW) age++;
      end
      if (!gl) for (int i = 0; i < LD; i++) ql[i] = 0;
      ml = gl && xl && !nh;
      mh = nh;
    end
  end

  task automatic check_now();
    checks++;
    if (en_hi !== mh || en_lo !== ml) begin
      fails++;
      $display("FAIL %s at %0t: actual en_hi=%b en_lo=%b expected en_hi=%b en_lo=%b",
               tag, $time, en_hi, en_lo, mh, ml);
    end
  endtask

  task automatic drive(input logic h, input logic l, input logic s,
                       input logic ph, input logic pl, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_now();
      cmd_hi = h; cmd_lo = l; shdn_n = s; pgood_hi = ph; pgood_lo = pl;
    end
  endtask

  task automatic cmd(input logic h, input logic l, input int n);
    drive(h, l, 1, 1, 1, n);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL R1 watchdog: actual still running, expected finished");
    finish_run();
  end

  initial begin
    tag = "R1"; cmd_hi = 1;
    repeat (3) begin @(negedge clk); check_now(); end
    rst_n = 1;
    cmd(0, 0, 4);
    tag = "R5"; cmd(1, 0, 12); cmd(0, 0, 12); cmd(0, 1, 12); cmd(0, 0, 12);
    tag = "R2"; cmd(1, 0, 2); cmd(1, 1, 10); cmd(0, 1, 10); cmd(1, 1, 4); cmd(1, 0, 10); cmd(0, 0, 12);
    tag = "R6"; cmd(1, 0, 1); cmd(0, 0, 12); cmd(1, 0, 3); cmd(0, 0, 12);
    tag = "R7"; cmd(1, 0, 15); cmd(0, 0, 1); cmd(1, 0, 15); cmd(0, 0, 2); cmd(1, 0, 8); cmd(0, 0, 12);
    tag = "R8"; cmd(0, 1, 1); cmd(0, 0, 10); cmd(1, 0, 1); cmd(0, 0, 12);
    tag = "R9"; cmd(1, 0, 1); cmd(0, 1, 6); cmd(0, 0, 12); cmd(0, 1, 6); cmd(1, 0, 1); cmd(0, 0, 12);
    tag = "R10"; cmd(1, 0, 8); cmd(0, 0, 7); cmd(1, 0, MW); cmd(0, 0, 12);
    tag = "R3"; cmd(1, 0, 10); drive(1, 0, 0, 1, 1, 3); cmd(1, 0, 12); cmd(0, 0, 12);
    cmd(1, 0, 1); cmd(0, 0, 6); drive(0, 0, 0, 1, 1, 1); cmd(0, 0, 12);
    cmd(0, 1, 3); drive(0, 1, 0, 1, 1, 1); cmd(0, 0, 12);
    tag = "R4"; cmd(1, 0, 10); drive(1, 0, 1, 0, 1, 3); cmd(1, 0, 10); cmd(0, 0, 12);
    cmd(0, 1, 10); drive(0, 1, 1, 1, 0, 3); cmd(0, 1, 10);
    drive(0, 1, 1, 0, 1, 5); cmd(0, 0, 12);
    tag = "R1"; rst_n = 0; cmd(1, 0, 2); drive(1, 0, 1, 1, 1, 2);
    rst_n = 1; cmd(0, 0, 12);
    finish_run();
  end
endmodule